// File: doc/BRIEF.md
# Packed Lane Shifter with Rounding and Saturation

This block shifts every lane of a 32-bit packed operand in one operation. The operand is treated either as two 16-bit lanes or as four 8-bit lanes, and each lane is shifted on its own, with nothing carried across a lane boundary. Three plain shift kinds are offered: arithmetic right, logical right and logical left. The amount comes either from the low bits of a second register or from a small immediate field. A mode bit turns the right shifts into rounding shifts and the left shift into a signed saturating shift.

A fourth kind, the mixed shift, reads a signed amount from the second register. A non-negative amount gives a saturating left shift. A negative amount gives an arithmetic right shift by its magnitude, which rounds when the mode bit is set. Any lane that clamps during a saturating operation sets a sticky flag, and only reset clears it. The result is registered one cycle after the request.

A two-state controller tracks result validity. The states are ST_IDLE (no fresh result) and ST_DONE (the result register holds the answer to the previous cycle's request). There are three transitions. T_ACCEPT goes from ST_IDLE to ST_DONE when in_valid is high. T_BACK2BACK stays in ST_DONE when another request arrives. T_DRAIN goes from ST_DONE to ST_IDLE when in_valid is low. ST_IDLE also stays in ST_IDLE when no request arrives.

Top module: `simd_lane_shifter`

## Requirements
- R1: While and after reset, out_valid is 0, result is 0 and sat_flag is 0.
- R2: A request presented with in_valid high at a rising edge gives its result and out_valid = 1 after that edge. out_valid is 0 after any edge where in_valid was low, and result keeps its previous value.
- R3: lane8 = 1 selects four 8-bit lanes and lane8 = 0 selects two 16-bit lanes. Lane i occupies bits [i*W +: W], and no bit crosses between lanes.
- R4: kind = 2'b00 is an arithmetic right shift. With use_imm = 0, the amount is the low log2(W) bits of rs2, and the upper bits of rs2 are ignored.
- R5: kind = 2'b01 is a logical right shift with zero fill.
- R6: kind = 2'b10 with mode bit 0 clear is a left shift that drops the bits shifted out. It never changes sat_flag.
- R7: use_imm = 1 takes the amount from the low log2(W) bits of imm instead of rs2, for kinds 2'b00 to 2'b10.
- R8: With mode bit 0 set, a right shift by k > 0 adds bit k-1 of the original lane to the truncated result. A shift by 0 returns the lane unchanged, and a right shift never changes sat_flag.
- R9: kind = 2'b10 with mode bit 0 set treats the lanes as signed. If any bit shifted out differs from the result's sign bit, the lane clamps to the most positive or most negative value, following the sign of the input.
- R10: kind = 2'b11 reads a signed log2(W)+1-bit amount from the low bits of rs2 and ignores use_imm. A non-negative amount gives a saturating left shift, as in R9. A negative amount gives an arithmetic right shift by its magnitude, rounded as in R8 when mode bit 0 is set.
- R11: sat_flag goes high when any selected lane clamps, and it stays high until reset.
- R12: Mode bit 1 has no effect: modes 2'b10 and 2'b11 act as 2'b00 and 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| lane8 | input | 1 | 1: four 8-bit lanes, 0: two 16-bit lanes |
| kind | input | 2 | 00 arith right, 01 logical right, 10 left, 11 mixed signed |
| mode | input | 2 | Bit 0: round (right) or saturate (left); bit 1 ignored |
| use_imm | input | 1 | Take the amount from imm |
| rs1 | input | 32 | Packed operand |
| rs2 | input | 32 | Amount register (low bits used) |
| imm | input | 4 | Immediate amount |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Packed shifted result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is the mixed shift at its most negative amount. Here the magnitude equals the full lane width, so the lane collapses to its sign, and the rounding bit is the sign bit itself. The stimulus sets rs2 to 0x10 in 16-bit mode and 0x8 in 8-bit mode, with both positive and negative lanes and with rounding on and off. The sticky flag is held clear until those right-going mixed cases and all the plain shifts have run, so an accidental set is visible. Only then is a clamp forced, and the bench checks that the flag survives the plain operations that follow.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

    typedef enum logic [1:0] {
        KIND_SRA = 2'b00,
        KIND_SRL = 2'b01,
        KIND_SLL = 2'b10,
        KIND_MIX = 2'b11
    } shift_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/simd_shift_amt.sv
// Per-width amount and control decode shared by all lanes of one width.
module simd_shift_amt
    import simd_shift_pkg::*;
#(
    parameter int W = 16,
    localparam int LW = $clog2(W)
) (
    input  shift_kind_e     kind,
    input  logic            rnd_sat,
    input  logic            use_imm,
    input  logic [LW:0]     amt_reg,
    input  logic [LW-1:0]   amt_imm,
    output logic            dir_left,
    output logic            arith,
    output logic [LW:0]     mag,
    output logic            rnd_en,
    output logic            sat_en
);

    logic [LW-1:0] pick;

    assign pick = use_imm ? amt_imm : amt_reg[LW-1:0];

    always_comb begin
        dir_left = 1'b0;
        arith    = 1'b0;
        mag      = '0;
        rnd_en   = 1'b0;
        sat_en   = 1'b0;
        unique case (kind)
            KIND_SRA: begin
                arith  = 1'b1;
                mag    = {1'b0, pick};
                rnd_en = rnd_sat;
            end
            KIND_SRL: begin
                mag    = {1'b0, pick};
                rnd_en = rnd_sat;
            end
            KIND_SLL: begin
                dir_left = 1'b1;
                mag      = {1'b0, pick};
                sat_en   = rnd_sat;
            end
            KIND_MIX: begin
                if (amt_reg[LW]) begin
                    arith  = 1'b1;
                    mag    = ~amt_reg + {{LW{1'b0}}, 1'b1};
                    rnd_en = rnd_sat;
                end else begin
                    dir_left = 1'b1;
                    mag      = amt_reg;
                    sat_en   = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/simd_shift_lane.sv
// One lane: right shift with optional rounding, left shift with optional clamp.
module simd_shift_lane #(
    parameter int W = 16,
    localparam int LW = $clog2(W)
) (
    input  logic [W-1:0] a,
    input  logic         dir_left,
    input  logic         arith,
    input  logic [LW:0]  mag,
    input  logic         rnd_en,
    input  logic         sat_en,
    output logic [W-1:0] y,
    output logic         ovf
);

    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [2*W-1:0] r_ext;
    logic [2*W-1:0] r_sh;
    logic [2*W-1:0] r_rb;
    logic [2*W-1:0] l_ext;
    logic [2*W-1:0] l_sh;
    logic [W-1:0]   r_val;
    logic [W-1:0]   l_val;
    logic           rbit;
    logic           lost;
    logic           unused_hi;

    always_comb begin
        r_ext = {{W{arith & a[W-1]}}, a};
        r_sh  = r_ext >> mag;
        r_rb  = r_ext >> (mag - {{LW{1'b0}}, 1'b1});
        rbit  = rnd_en && (mag != '0) && r_rb[0];
        r_val = r_sh[W-1:0] + {{(W-1){1'b0}}, rbit};

        l_ext = {{W{a[W-1]}}, a};
        l_sh  = l_ext << mag;
        lost  = !((&l_sh[2*W-1:W-1]) || !(|l_sh[2*W-1:W-1]));
        l_val = (sat_en && lost) ? (a[W-1] ? NEG_MIN : POS_MAX) : l_sh[W-1:0];

        y   = dir_left ? l_val : r_val;
        ovf = dir_left && sat_en && lost;
    end

    assign unused_hi = ^{r_sh[2*W-1:W], r_rb[2*W-1:1]};

endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter
    import simd_shift_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8,
    localparam int WLW      = $clog2(WIDE_W),
    localparam int NLW      = $clog2(NARROW_W),
    localparam int IMM_W    = WLW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              lane8,
    input  logic [1:0]        kind,
    input  logic [1:0]        mode,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] rs1,
    input  logic [DATA_W-1:0] rs2,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);

    localparam int N_WIDE   = DATA_W / WIDE_W;
    localparam int N_NARROW = DATA_W / NARROW_W;

    shift_kind_e       kind_e;
    ctl_state_e        state_q;
    ctl_state_e        state_d;
    logic [DATA_W-1:0] wide_res;
    logic [DATA_W-1:0] narrow_res;
    logic [N_WIDE-1:0]   wide_ovf;
    logic [N_NARROW-1:0] narrow_ovf;
    logic [DATA_W-1:0] sel_res;
    logic              sel_ovf;
    logic [DATA_W-1:0] result_q;
    logic              sat_q;
    logic              unused_in;

    assign kind_e    = shift_kind_e'(kind);
    assign unused_in = ^{rs2[DATA_W-1:WLW+1], mode[1]};

    // 16-bit lanes
    logic            w_left, w_arith, w_rnd, w_sat;
    logic [WLW:0]    w_mag;

    simd_shift_amt #(.W(WIDE_W)) u_amt_wide (
        .kind     (kind_e),
        .rnd_sat  (mode[0]),
        .use_imm  (use_imm),
        .amt_reg  (rs2[WLW:0]),
        .amt_imm  (imm[WLW-1:0]),
        .dir_left (w_left),
        .arith    (w_arith),
        .mag      (w_mag),
        .rnd_en   (w_rnd),
        .sat_en   (w_sat)
    );

    for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
        simd_shift_lane #(.W(WIDE_W)) u_lane (
            .a        (rs1[i*WIDE_W +: WIDE_W]),
            .dir_left (w_left),
            .arith    (w_arith),
            .mag      (w_mag),
            .rnd_en   (w_rnd),
            .sat_en   (w_sat),
            .y        (wide_res[i*WIDE_W +: WIDE_W]),
            .ovf      (wide_ovf[i])
        );
    end

    // 8-bit lanes
    logic            n_left, n_arith, n_rnd, n_sat;
    logic [NLW:0]    n_mag;

    simd_shift_amt #(.W(NARROW_W)) u_amt_narrow (
        .kind     (kind_e),
        .rnd_sat  (mode[0]),
        .use_imm  (use_imm),
        .amt_reg  (rs2[NLW:0]),
        .amt_imm  (imm[NLW-1:0]),
        .dir_left (n_left),
        .arith    (n_arith),
        .mag      (n_mag),
        .rnd_en   (n_rnd),
        .sat_en   (n_sat)
    );

    for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
        simd_shift_lane #(.W(NARROW_W)) u_lane (
            .a        (rs1[i*NARROW_W +: NARROW_W]),
            .dir_left (n_left),
            .arith    (n_arith),
            .mag      (n_mag),
            .rnd_en   (n_rnd),
            .sat_en   (n_sat),
            .y        (narrow_res[i*NARROW_W +: NARROW_W]),
            .ovf      (narrow_ovf[i])
        );
    end

    assign sel_res = lane8 ? narrow_res : wide_res;
    assign sel_ovf = lane8 ? (|narrow_ovf) : (|wide_ovf);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;  // T_ACCEPT
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;  // T_BACK2BACK / T_DRAIN
        endcase
    end

    // Outputs from state
    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_DONE: out_valid = 1'b1;
        endcase
    end

    // Result and sticky flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            sat_q    <= 1'b0;
        end else if (in_valid) begin
            result_q <= sel_res;
            sat_q    <= sat_q | sel_ovf;
        end
    end

    assign result   = result_q;
    assign sat_flag = sat_q;

endmodule

// File: rtl/simd_lane_shifter_chk.sv
module simd_lane_shifter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  kind,
    input logic [1:0]  mode,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        sat_flag
);

    assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_valid_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_result_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |=> sat_flag);

    assert_plain_left_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'b10 && !mode[0] && !sat_flag) |=> !sat_flag);

    assert_right_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !kind[1] && !sat_flag) |=> !sat_flag);

endmodule

bind simd_lane_shifter simd_lane_shifter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .kind      (kind),
    .mode      (mode),
    .out_valid (out_valid),
    .result    (result),
    .sat_flag  (sat_flag)
);

// File: tb/simd_lane_shifter_tb.sv
`timescale 1ns/1ps
module simd_lane_shifter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        lane8 = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [1:0]  mode = 2'b00;
    logic        use_imm = 1'b0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;
    logic [3:0]  imm = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_flag;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  exp_sat = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    simd_lane_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane8(lane8),
        .kind(kind), .mode(mode), .use_imm(use_imm), .rs1(rs1), .rs2(rs2),
        .imm(imm), .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_shift(input int k, input bit n8, input bit m0,
                                              input bit ui, input logic [31:0] a,
                                              input logic [31:0] b, input logic [3:0] im,
                                              output bit sat);
        int w;
        int lanes;
        longint mask;
        logic [31:0] res;
        w = n8 ? 8 : 16;
        lanes = 32 / w;
        mask = (64'sd1 <<< w) - 1;
        res = '0;
        sat = 1'b0;
        for (int i = 0; i < lanes; i++) begin
            longint u, sv, v, r, p, maxv, minv;
            int amt, m;
            bit left, rnd, sten;
            u = longint'({32'd0, a >> (i*w)}) & mask;
            sv = (u >= (64'sd1 <<< (w-1))) ? u - (64'sd1 <<< w) : u;
            maxv = (64'sd1 <<< (w-1)) - 1;
            minv = -(64'sd1 <<< (w-1));
            left = 0; rnd = 0; sten = 0; v = sv; m = 0;
            if (k == 3) begin
                amt = int'(b & (2*w - 1));
                if (amt >= w) amt = amt - 2*w;
                if (amt < 0) begin m = -amt; rnd = m0; end
                else begin left = 1; sten = 1; m = amt; end
            end else begin
                m = ui ? int'(im & 4'(w-1)) : int'(b & (w-1));
                if (k == 2) begin left = 1; sten = m0; end
                else begin rnd = m0; v = (k == 1) ? u : sv; end
            end
            if (left) begin
                p = sv <<< m;
                if (sten && p > maxv) begin r = maxv; sat = 1; end
                else if (sten && p < minv) begin r = minv; sat = 1; end
                else r = p;
            end else if (m == 0) begin
                r = v;
            end else begin
                r = (v >>> m) + (rnd ? ((v >>> (m-1)) & 1) : 0);
            end
            res = res | (32'(r & mask) << (i*w));
        end
        return res;
    endfunction

    task automatic op(input string req, input int k, input bit n8, input logic [1:0] md,
                      input bit ui, input logic [31:0] a, input logic [31:0] b,
                      input logic [3:0] im);
        logic [31:0] e;
        bit s;
        @(negedge clk);
        in_valid = 1'b1; lane8 = n8; kind = 2'(k); mode = md; use_imm = ui;
        rs1 = a; rs2 = b; imm = im;
        e = ref_shift(k, n8, md[0], ui, a, b, im, s);
        exp_sat = exp_sat | s;
        @(negedge clk);
        chk({req, " result"}, result, e);
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({req, " flag"}, {31'd0, sat_flag}, {31'd0, exp_sat});
        in_valid = 1'b0;
    endtask

    task automatic t_reset(input string req);
        chk({req, " valid"}, {31'd0, out_valid}, 32'd0);
        chk({req, " result"}, result, 32'd0);
        chk({req, " flag"}, {31'd0, sat_flag}, 32'd0);
    endtask

    task automatic t_sra();   // R4, R3
        op("R4 sra16", 0, 0, 2'b00, 0, 32'h8000_7FFF, 32'hFFFF_FFF3, 4'h0);
        op("R4 sra8",  0, 1, 2'b00, 0, 32'h80_7F_C3_01, 32'hABCD_EF02, 4'h0);
        op("R3 sra16 zero", 0, 0, 2'b00, 0, 32'h1234_F00F, 32'h0000_0010, 4'h0);
    endtask

    task automatic t_srl();   // R5
        op("R5 srl16", 1, 0, 2'b00, 0, 32'h8000_FFFF, 32'h0000_000F, 4'h0);
        op("R5 srl8",  1, 1, 2'b00, 0, 32'hFF_80_41_10, 32'h0000_0007, 4'h0);
    endtask

    task automatic t_sll_plain();   // R6
        op("R6 sll16", 2, 0, 2'b00, 0, 32'h4001_C003, 32'h0000_0005, 4'h0);
        op("R6 sll8",  2, 1, 2'b00, 0, 32'h7F_81_40_C0, 32'h0000_0003, 4'h0);
    endtask

    task automatic t_imm();   // R7
        op("R7 imm sra16", 0, 0, 2'b00, 1, 32'hF000_0F00, 32'h0000_0001, 4'h8);
        op("R7 imm srl8",  1, 1, 2'b00, 1, 32'hF0_0F_88_77, 32'h0000_0000, 4'hE);
    endtask

    task automatic t_round();   // R8
        op("R8 rnd sra16", 0, 0, 2'b01, 0, 32'hFFF9_0007, 32'h0000_0001, 4'h0);
        op("R8 rnd srl8",  1, 1, 2'b01, 0, 32'hFF_17_0C_03, 32'h0000_0002, 4'h0);
        op("R8 rnd zero",  0, 1, 2'b01, 0, 32'h81_7F_FF_01, 32'h0000_0000, 4'h0);
        op("R8 rnd imm",   0, 0, 2'b01, 1, 32'h8001_7FFF, 32'h0000_0000, 4'hF);
    endtask

    task automatic t_mix_right();   // R10
        op("R10 mix -3 rnd", 3, 0, 2'b01, 0, 32'hFFF3_0015, 32'h0000_001D, 4'h0);
        op("R10 mix -16",    3, 0, 2'b00, 0, 32'h8000_7FFF, 32'h0000_0010, 4'h0);
        op("R10 mix -16 rnd",3, 0, 2'b01, 1, 32'h8000_7FFF, 32'h0000_0010, 4'h3);
        op("R10 mix8 -8 rnd",3, 1, 2'b01, 0, 32'h80_7F_C0_01, 32'h0000_0008, 4'h0);
    endtask

    task automatic t_mix_left();   // R10 left, R11
        op("R10 mix +2 noclamp", 3, 0, 2'b00, 0, 32'h0FFF_F000, 32'h0000_0002, 4'h0);
        op("R10 mix8 +7 clamp",  3, 1, 2'b00, 0, 32'h01_FF_02_FE, 32'h0000_0007, 4'h0);
    endtask

    task automatic t_sat();   // R9, R11
        op("R9 sat16", 2, 0, 2'b01, 0, 32'h4000_C000, 32'h0000_0001, 4'h0);
        op("R9 sat8",  2, 1, 2'b01, 0, 32'h20_DF_10_F0, 32'h0000_0002, 4'h0);
    endtask

    task automatic t_sticky();   // R11
        op("R11 plain after clamp", 1, 0, 2'b00, 0, 32'h1234_5678, 32'h0000_0004, 4'h0);
        op("R11 sll after clamp",   2, 0, 2'b00, 0, 32'h7FFF_7FFF, 32'h0000_0004, 4'h0);
    endtask

    task automatic t_mode_hi();   // R12
        op("R12 mode 11 round", 0, 0, 2'b11, 0, 32'hFFF9_0007, 32'h0000_0002, 4'h0);
        op("R12 mode 10 plain", 0, 0, 2'b10, 0, 32'hFFF9_0007, 32'h0000_0002, 4'h0);
        op("R12 mode 11 sat",   2, 1, 2'b11, 0, 32'h7F_80_01_FF, 32'h0000_0004, 4'h0);
    endtask

    task automatic t_timing();   // R2
        logic [31:0] held;
        logic [31:0] e1, e2;
        bit s;
        e1 = ref_shift(1, 0, 0, 0, 32'hAAAA_5555, 32'h1, 4'h0, s);
        e2 = ref_shift(0, 1, 0, 0, 32'h8844_2211, 32'h3, 4'h0, s);
        @(negedge clk);
        in_valid = 1'b1; lane8 = 0; kind = 2'b01; mode = 2'b00; use_imm = 0;
        rs1 = 32'hAAAA_5555; rs2 = 32'h1;
        @(negedge clk);
        chk("R2 first of pair", result, e1);
        lane8 = 1; kind = 2'b00; rs1 = 32'h8844_2211; rs2 = 32'h3;
        @(negedge clk);
        chk("R2 second of pair", result, e2);
        chk("R2 valid pair", {31'd0, out_valid}, 32'd1);
        in_valid = 1'b0;
        held = result;
        rs1 = 32'hDEAD_BEEF;
        @(negedge clk);
        chk("R2 valid drops", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R2 result held", result, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset("R1 initial");
        rst_n = 1'b1;
        @(negedge clk);
        t_reset("R1 after release");
        t_sra();
        t_srl();
        t_sll_plain();
        t_imm();
        t_round();
        t_mix_right();
        t_timing();
        t_mix_left();
        t_sat();
        t_sticky();
        t_mode_hi();
        @(negedge clk);
        rst_n = 1'b0;
        exp_sat = 1'b0;
        @(negedge clk);
        t_reset("R1 R11 reset clears");
        rst_n = 1'b1;
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule